// File: doc/BRIEF.md
# Qualified Power-Good Delay Generator

This block drives the power-good signal that a downstream system waits on before it leaves reset. It collects a set of qualifying conditions: the comparator result for a separate power-good sense input, one under-voltage-OK flag per supply rail, the fault flag from the supply supervisor and the on/off command. It raises power-good only after every condition has held without interruption for a short noise-debounce interval followed by a long hold-off.

Time is measured in ticks of a clock-enable strobe, so the hold-off can span hundreds of milliseconds without a wide counter running at the full clock rate. With a 1 µs tick the default counts give 73 µs of debounce and 300 ms of hold-off.

Power-good falls in the same cycle that any condition is lost, with no register in that path. If a condition drops while the block is still debouncing or holding off, the count is discarded. The full interval starts again from zero once every condition is back.

Top module: `pg_delay_gen`

## Requirements
- R1: `pg_out` is high only while `pgi_ok` is 1 and every bit of `rail_ok` is 1.
- R2: `pg_out` is low in every cycle in which `fault` is 1 or `supply_on` is 0.
- R3: When any qualifying condition (R1, R2) is lost, `pg_out` is low in that same cycle, with no register delay.
- R4: With every condition true, `pg_out` rises right after the clock edge that registers the (DEB_TICKS + HOLD_TICKS)-th qualified tick, and not before.
- R5: Only cycles in which `tick` is 1 advance the interval; cycles with `tick` 0 leave it unchanged.
- R6: A loss of any condition during the debounce or the hold-off clears the count, and the full DEB_TICKS + HOLD_TICKS interval must be served again.
- R7: Synchronous active-high `rst` clears both counters and holds `pg_out` low for the following cycle.
- R8: Once `pg_out` is high, it stays high for as long as every condition remains true, whether or not further ticks arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timebase strobe; one pulse per time unit |
| pgi_ok | input | 1 | Power-good sense input is above its threshold |
| rail_ok | input | NUM_RAILS | Per-rail flag: the rail is above its under-voltage threshold |
| fault | input | 1 | Supervisor reports a latched fault |
| supply_on | input | 1 | The supply is commanded on |
| pg_out | output | 1 | Power-good, active high |

## Verification
On every cycle the assertions check three things about `pg_out`. It is never high while a condition is missing. It drops in the very cycle a condition goes away. A rising edge follows at least the full tick count, measured by an independent qualified-tick counter. The exact rising cycle, the restart after a dropout inside each phase, and the fact that idle cycles do not count can only be shown by the bench's scenarios. In those scenarios a reference count of qualified ticks is compared with the output, both for directed boundary sequences and for random ones.

// File: rtl/pgd_pkg.sv
package pgd_pkg;

    typedef enum logic [1:0] {
        ST_DEBOUNCE = 2'd0,
        ST_HOLDOFF  = 2'd1,
        ST_GOOD     = 2'd2
    } pgd_stage_t;

    typedef struct packed {
        logic sense_ok;
        logic rails_ok;
        logic no_fault;
        logic enabled;
    } pgd_cond_t;

    function automatic int unsigned cnt_width(input int unsigned limit);
        return (limit > 1) ? $clog2(limit) : 1;
    endfunction

    function automatic logic cond_all(input pgd_cond_t c);
        return c.sense_ok & c.rails_ok & c.no_fault & c.enabled;
    endfunction

endpackage

// File: rtl/pgd_qualify.sv
module pgd_qualify
    import pgd_pkg::*;
#(
    parameter int unsigned NUM_RAILS = 3
) (
    input  logic                 pgi_ok,
    input  logic [NUM_RAILS-1:0] rail_ok,
    input  logic                 fault,
    input  logic                 supply_on,
    output pgd_cond_t            cond,
    output logic                 qualified
);

    always_comb begin
        cond.sense_ok = pgi_ok;
        cond.rails_ok = &rail_ok;
        cond.no_fault = ~fault;
        cond.enabled  = supply_on;
        qualified     = cond_all(cond);
    end

endmodule

// File: rtl/pgd_tick_counter.sv
module pgd_tick_counter
    import pgd_pkg::*;
#(
    parameter int unsigned LIMIT = 73
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic adv,
    output logic done
);

    localparam int unsigned W = cnt_width(LIMIT);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt_q;

    assign done = adv && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (adv) begin
            cnt_q <= done ? '0 : cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/pgd_sequencer.sv
module pgd_sequencer
    import pgd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       qualified,
    input  logic       deb_done,
    input  logic       hold_done,
    output pgd_stage_t stage
);

    pgd_stage_t stage_d;

    always_comb begin
        stage_d = stage;
        if (!qualified) begin
            stage_d = ST_DEBOUNCE;
        end else begin
            unique case (stage)
                ST_DEBOUNCE: if (deb_done)  stage_d = ST_HOLDOFF;
                ST_HOLDOFF:  if (hold_done) stage_d = ST_GOOD;
                ST_GOOD:     stage_d = ST_GOOD;
                default:     stage_d = ST_DEBOUNCE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) stage <= ST_DEBOUNCE;
        else     stage <= stage_d;
    end

endmodule

// File: rtl/pg_delay_gen.sv
module pg_delay_gen
    import pgd_pkg::*;
#(
    parameter int unsigned NUM_RAILS  = 3,
    parameter int unsigned DEB_TICKS  = 73,
    parameter int unsigned HOLD_TICKS = 300000
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic                 pgi_ok,
    input  logic [NUM_RAILS-1:0] rail_ok,
    input  logic                 fault,
    input  logic                 supply_on,
    output logic                 pg_out
);

    pgd_cond_t  cond;
    logic       qualified;
    pgd_stage_t stage;
    logic       deb_done;
    logic       hold_done;
    logic       in_deb;
    logic       in_hold;

    pgd_qualify #(.NUM_RAILS(NUM_RAILS)) u_qual (
        .pgi_ok    (pgi_ok),
        .rail_ok   (rail_ok),
        .fault     (fault),
        .supply_on (supply_on),
        .cond      (cond),
        .qualified (qualified)
    );

    assign in_deb  = (stage == ST_DEBOUNCE);
    assign in_hold = (stage == ST_HOLDOFF);

    pgd_tick_counter #(.LIMIT(DEB_TICKS)) u_deb_cnt (
        .clk  (clk),
        .rst  (rst),
        .clr  (!qualified || !in_deb),
        .adv  (qualified && in_deb && tick),
        .done (deb_done)
    );

    pgd_tick_counter #(.LIMIT(HOLD_TICKS)) u_hold_cnt (
        .clk  (clk),
        .rst  (rst),
        .clr  (!qualified || !in_hold),
        .adv  (qualified && in_hold && tick),
        .done (hold_done)
    );

    pgd_sequencer u_seq (
        .clk       (clk),
        .rst       (rst),
        .qualified (qualified),
        .deb_done  (deb_done),
        .hold_done (hold_done),
        .stage     (stage)
    );

    assign pg_out = (stage == ST_GOOD) && cond_all(cond);

endmodule

// File: rtl/pgd_checker.sv
module pgd_checker #(
    parameter int unsigned NUM_RAILS  = 3,
    parameter int unsigned DEB_TICKS  = 73,
    parameter int unsigned HOLD_TICKS = 300000
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 tick,
    input logic                 pgi_ok,
    input logic [NUM_RAILS-1:0] rail_ok,
    input logic                 fault,
    input logic                 supply_on,
    input logic                 pg_out
);

    localparam int unsigned TOTAL = DEB_TICKS + HOLD_TICKS;
    localparam int unsigned CW    = $clog2(TOTAL + 1);

    logic          ok_now;
    logic [CW-1:0] seen_q;

    assign ok_now = pgi_ok && (rail_ok == {NUM_RAILS{1'b1}}) && !fault && supply_on;

    always_ff @(posedge clk) begin
        if (rst || !ok_now)                    seen_q <= '0;
        else if (tick && seen_q != CW'(TOTAL)) seen_q <= seen_q + 1'b1;
    end

    a_r1_needs_sense_and_rails: assert property (@(posedge clk) disable iff (rst)
        pg_out |-> (pgi_ok && (rail_ok == {NUM_RAILS{1'b1}})));

    a_r2_fault_or_off_low: assert property (@(posedge clk) disable iff (rst)
        (fault || !supply_on) |-> !pg_out);

    a_r3_drop_same_cycle: assert property (@(posedge clk) disable iff (rst)
        (pg_out == 1'b0) || ok_now);

    a_r4_full_interval: assert property (@(posedge clk) disable iff (rst)
        $rose(pg_out) |-> (seen_q == CW'(TOTAL)));

    a_r8_stays_high: assert property (@(posedge clk) disable iff (rst)
        (pg_out && ok_now) |=> (pg_out || !ok_now));

    a_r7_reset_low: assert property (@(posedge clk)
        rst |=> !pg_out);

endmodule

bind pg_delay_gen pgd_checker #(
    .NUM_RAILS  (NUM_RAILS),
    .DEB_TICKS  (DEB_TICKS),
    .HOLD_TICKS (HOLD_TICKS)
) u_pgd_checker (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .pgi_ok    (pgi_ok),
    .rail_ok   (rail_ok),
    .fault     (fault),
    .supply_on (supply_on),
    .pg_out    (pg_out)
);

// File: tb/tb_pg_delay_gen.sv
module tb_pg_delay_gen;

    localparam int unsigned NR    = 3;
    localparam int unsigned DEB   = 3;
    localparam int unsigned HOLD  = 10;
    localparam int unsigned TOTAL = DEB + HOLD;

    logic          clk = 1'b0;
    logic          rst;
    logic          tick;
    logic          pgi_ok;
    logic [NR-1:0] rail_ok;
    logic          fault;
    logic          supply_on;
    logic          pg_out;

    int checks = 0;
    int fails  = 0;
    int mcnt   = 0;

    always #10 clk = ~clk;

    pg_delay_gen #(.NUM_RAILS(NR), .DEB_TICKS(DEB), .HOLD_TICKS(HOLD)) dut (
        .clk(clk), .rst(rst), .tick(tick), .pgi_ok(pgi_ok), .rail_ok(rail_ok),
        .fault(fault), .supply_on(supply_on), .pg_out(pg_out)
    );

    function automatic logic model_ok(logic p, logic [NR-1:0] r, logic f, logic on);
        return p && (r == {NR{1'b1}}) && !f && on;
    endfunction

    function automatic logic model_pg(logic ok, int cnt);
        return ok && (cnt == TOTAL);
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: pg_out=%0b expected %0b (ticks=%0d)", req, act, exp, mcnt);
        end
    endtask

    task automatic step(input logic p, input logic [NR-1:0] r, input logic f,
                        input logic on, input logic t, input string req);
        logic ok;
        @(negedge clk);
        pgi_ok = p; rail_ok = r; fault = f; supply_on = on; tick = t;
        ok = model_ok(p, r, f, on);
        @(posedge clk);
        if (rst || !ok)            mcnt = 0;
        else if (t && mcnt < TOTAL) mcnt++;
        #5;
        check(req, pg_out, model_pg(ok, mcnt));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        rst = 1'b1; tick = 1'b0; pgi_ok = 1'b0; rail_ok = '0; fault = 1'b0; supply_on = 1'b0;
        repeat (3) @(posedge clk);
        #5;
        check("R7 reset low", pg_out, 1'b0);
        @(negedge clk);
        rst = 1'b0;

        // R4: exact boundary with a tick every cycle
        for (int i = 0; i < TOTAL; i++) step(1, '1, 0, 1, 1, "R4 rise boundary");
        check("R4 high after full count", pg_out, 1'b1);
        // R8: stays high without ticks
        for (int i = 0; i < 5; i++) step(1, '1, 0, 1, 0, "R8 hold high");
        // R3: drop of one rail is immediate
        @(negedge clk);
        rail_ok = 3'b101;
        #1;
        check("R3 same-cycle drop", pg_out, 1'b0);
        step(1, 3'b101, 0, 1, 1, "R1 rail low");
        // R2: fault and off each force low
        for (int i = 0; i < TOTAL + 2; i++) step(1, '1, 1, 1, 1, "R2 fault forces low");
        for (int i = 0; i < TOTAL + 2; i++) step(1, '1, 0, 0, 1, "R2 off forces low");
        step(0, '1, 0, 1, 1, "R1 sense low");

        // R6: dropout inside debounce, then inside hold-off
        for (int i = 0; i < DEB - 1; i++) step(1, '1, 0, 1, 1, "R6 debounce part");
        step(0, '1, 0, 1, 1, "R6 drop in debounce");
        for (int i = 0; i < TOTAL - 1; i++) step(1, '1, 0, 1, 1, "R6 restart");
        step(1, 3'b011, 0, 1, 1, "R6 drop in hold-off");
        for (int i = 0; i < TOTAL - 1; i++) step(1, '1, 0, 1, 1, "R6 restart again");
        check("R6 still low one tick short", pg_out, 1'b0);
        step(1, '1, 0, 1, 1, "R6 final tick");

        // R5: idle cycles do not advance
        step(1, '1, 1, 1, 1, "R5 clear");
        for (int i = 0; i < 40; i++) step(1, '1, 0, 1, 0, "R5 no tick no count");
        for (int i = 0; i < TOTAL; i++) begin
            step(1, '1, 0, 1, 0, "R5 gap");
            step(1, '1, 0, 1, 1, "R5 sparse ticks");
        end

        // R7: reset while good
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        mcnt = 0;
        #5;
        check("R7 reset clears", pg_out, 1'b0);
        @(negedge clk);
        rst = 1'b0;

        // random mix
        for (int i = 0; i < 4000; i++) begin
            logic [NR-1:0] r;
            r = ($urandom % 40 == 0) ? NR'($urandom) : '1;
            step(($urandom % 50) != 0, r, ($urandom % 80) == 0, ($urandom % 60) != 0,
                 ($urandom % 3) == 0, "R4 random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule